// File: doc/BRIEF.md
# Aliased Sub-Register File

This block holds eight 32-bit general-purpose registers in which narrower views share storage with the full register. Any register can be accessed as a whole 32-bit value or through its low 16 bits. Registers 0 to 3 can also be accessed through their bits 7:0 or bits 15:8. A narrow write merges into the stored value and leaves every bit outside the addressed view as it was. This differs from a register file of independent fixed-width words.

There is one write port and there are two combinational read ports. Each port has a register index and a view selector. Each read port can also widen a byte or word view to 16 or 32 bits, using zero fill or sign fill. Register 4 serves as the stack pointer. A push request and a pop request adjust it by four bytes and produce the matching memory address in the same cycle. The memory and the instruction decoder lie outside the block.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so registers leave reset on the second rising clock edge after `rst_n` goes high.

Top module: `aliased_regfile`

## Requirements
- R1: After reset every register reads as zero through the full 32-bit view.
- R2: A write with view code 0 (full 32 bits) replaces the whole register. The new value is readable from the cycle after the write edge.
- R3: A write with view code 1 (bits 15:0) loads `wr_data[15:0]` into bits 15:0 and leaves bits 31:16 unchanged.
- R4: On registers 0 to 3, view code 2 writes `wr_data[7:0]` into bits 7:0 and view code 3 writes `wr_data[7:0]` into bits 15:8. All other bits are kept.
- R5: A write with view code 2 or 3 to register 4, 5, 6 or 7 raises `wr_err` combinationally in that cycle, and no register changes.
- R6: A read with view code 2 or 3 of register 4, 5, 6 or 7 returns zero.
- R7: Read widening works as follows. With `*_sext`=1 the fill copies the top bit of the view; with `*_sext`=0 the fill is zero. With `*_narrow`=0 a byte or word view is widened to 32 bits. With `*_narrow`=1 a byte view is widened to 16 bits and bits 31:16 are zero. A word view with `*_narrow`=1 is returned zero-filled. View code 0 is always returned unchanged.
- R8: While `push` is high, `stk_addr` equals register 4 minus 4. At the clock edge, register 4 takes that value.
- R9: While `pop` is high and `push` is low, `stk_addr` equals register 4. At the clock edge, register 4 increases by 4.
- R10: When `push` and `pop` are both high, `push` takes effect and `pop` is ignored. Any stack adjustment overrides a write to register 4 in the same cycle.
- R11: A read in the same cycle as a write to an overlapping view returns the old contents. There is no bypass.
- R12: Both read ports select and widen independently, from the same stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index to write |
| wr_view | input | 2 | Write view: 0 full, 1 bits 15:0, 2 bits 7:0, 3 bits 15:8 |
| wr_data | input | 32 | Write data, right-aligned for narrow views |
| wr_err | output | 1 | Illegal byte view on a write |
| ra_idx | input | 3 | Port A register index |
| ra_view | input | 2 | Port A view code |
| ra_sext | input | 1 | Port A sign fill when 1 |
| ra_narrow | input | 1 | Port A 16-bit target when 1 |
| ra_data | output | 32 | Port A read data |
| rb_idx | input | 3 | Port B register index |
| rb_view | input | 2 | Port B view code |
| rb_sext | input | 1 | Port B sign fill when 1 |
| rb_narrow | input | 1 | Port B 16-bit target when 1 |
| rb_data | output | 32 | Port B read data |
| push | input | 1 | Stack push request |
| pop | input | 1 | Stack pop request |
| stk_addr | output | 32 | Stack memory address for the current request |

## Verification
The assertions assume that `wr_idx`, `wr_view`, `push` and `pop` carry known values whenever the internal reset is released. They make no assumption about which operations can share a cycle. The stimulus therefore drives every input to a defined value at all times. Its random phase deliberately combines illegal byte views, push and pop in the same cycle, and writes to register 4 during a stack adjustment, so that the priority properties are exercised rather than avoided.

// File: rtl/arf_pkg.sv
package arf_pkg;
  typedef enum logic [1:0] {
    VW_FULL = 2'd0,
    VW_HALF = 2'd1,
    VW_BLO  = 2'd2,
    VW_BHI  = 2'd3
  } view_e;
endpackage

// File: rtl/rf_write_merge.sv
module rf_write_merge
  import arf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_val,
  input  view_e         view,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] merged
);
  localparam int HW = DW / 2;
  localparam int BW = 8;

  always_comb begin
    merged = old_val;
    unique case (view)
      VW_FULL: merged = din;
      VW_HALF: merged[HW-1:0] = din[HW-1:0];
      VW_BLO:  merged[BW-1:0] = din[BW-1:0];
      VW_BHI:  merged[2*BW-1:BW] = din[BW-1:0];
      default: merged = old_val;
    endcase
  end
endmodule

// File: rtl/rf_read_view.sv
module rf_read_view
  import arf_pkg::*;
#(
  parameter int DW        = 32,
  parameter int IW        = 3,
  parameter int BYTE_REGS = 4
) (
  input  logic [DW-1:0] src,
  input  logic [IW-1:0] idx,
  input  view_e         view,
  input  logic          sext,
  input  logic          narrow,
  output logic [DW-1:0] dout
);
  localparam int HW = DW / 2;
  localparam int BW = 8;
  localparam logic [IW-1:0] BYTE_LIM = IW'(BYTE_REGS);

  logic [HW-1:0] half_v;
  logic [BW-1:0] byte_v;
  logic [HW-1:0] byte_to_half;
  logic          byte_ok;

  always_comb begin
    half_v       = src[HW-1:0];
    byte_v       = (view == VW_BHI) ? src[2*BW-1:BW] : src[BW-1:0];
    byte_ok      = (idx < BYTE_LIM);
    byte_to_half = {{(HW-BW){sext & byte_v[BW-1]}}, byte_v};
    unique case (view)
      VW_FULL: dout = src;
      VW_HALF: dout = narrow ? {{HW{1'b0}}, half_v}
                             : {{HW{sext & half_v[HW-1]}}, half_v};
      VW_BLO, VW_BHI: begin
        if (!byte_ok)    dout = '0;
        else if (narrow) dout = {{HW{1'b0}}, byte_to_half};
        else             dout = {{HW{sext & byte_v[BW-1]}}, byte_to_half};
      end
      default: dout = '0;
    endcase
  end
endmodule

// File: rtl/rf_stack_ctl.sv
module rf_stack_ctl #(
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic [DW-1:0] sp_cur,
  input  logic          push,
  input  logic          pop,
  output logic          act,
  output logic [DW-1:0] sp_nxt,
  output logic [DW-1:0] addr
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  always_comb begin
    act    = push | pop;
    sp_nxt = sp_cur;
    addr   = sp_cur;
    if (push) begin
      sp_nxt = sp_cur - STEP_V;
      addr   = sp_cur - STEP_V;
    end else if (pop) begin
      sp_nxt = sp_cur + STEP_V;
      addr   = sp_cur;
    end
  end
endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile
  import arf_pkg::*;
#(
  parameter int NREG      = 8,
  parameter int DW        = 32,
  parameter int BYTE_REGS = 4,
  parameter int SP_IDX    = 4,
  parameter int STEP      = 4,
  localparam int IW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_view,
  input  logic [DW-1:0] wr_data,
  output logic          wr_err,
  input  logic [IW-1:0] ra_idx,
  input  logic [1:0]    ra_view,
  input  logic          ra_sext,
  input  logic          ra_narrow,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  input  logic [1:0]    rb_view,
  input  logic          rb_sext,
  input  logic          rb_narrow,
  output logic [DW-1:0] rb_data,
  input  logic          push,
  input  logic          pop,
  output logic [DW-1:0] stk_addr
);
  localparam logic [IW-1:0] BYTE_LIM = IW'(BYTE_REGS);
  localparam logic [DW-1:0] STEP_V   = DW'(STEP);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] merged, sp_nxt;
  logic          wr_ok, stk_act;
  view_e         wv;

  assign wv     = view_e'(wr_view);
  assign wr_err = wr_en && (wv == VW_BLO || wv == VW_BHI) && (wr_idx >= BYTE_LIM);
  assign wr_ok  = wr_en && !wr_err;

  rf_write_merge #(.DW(DW)) u_merge (
    .old_val(regs[wr_idx]), .view(wv), .din(wr_data), .merged(merged)
  );

  rf_stack_ctl #(.DW(DW), .STEP(STEP)) u_stack (
    .sp_cur(regs[SP_IDX]), .push(push), .pop(pop),
    .act(stk_act), .sp_nxt(sp_nxt), .addr(stk_addr)
  );

  rf_read_view #(.DW(DW), .IW(IW), .BYTE_REGS(BYTE_REGS)) u_rd_a (
    .src(regs[ra_idx]), .idx(ra_idx), .view(view_e'(ra_view)),
    .sext(ra_sext), .narrow(ra_narrow), .dout(ra_data)
  );

  rf_read_view #(.DW(DW), .IW(IW), .BYTE_REGS(BYTE_REGS)) u_rd_b (
    .src(regs[rb_idx]), .idx(rb_idx), .view(view_e'(rb_view)),
    .sext(rb_sext), .narrow(rb_narrow), .dout(rb_data)
  );

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    localparam bit IS_SP = (gi == SP_IDX);
    logic          ld_en;
    logic [DW-1:0] ld_val;

    always_comb begin
      if (IS_SP && stk_act) begin
        ld_en  = 1'b1;
        ld_val = sp_nxt;
      end else begin
        ld_en  = wr_ok && (wr_idx == IW'(gi));
        ld_val = merged;
      end
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)  regs[gi] <= '0;
      else if (ld_en)  regs[gi] <= ld_val;
    end

    // R3: a half write keeps the upper bits
    a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_en && wr_idx == IW'(gi) && wr_view == 2'd1 && !(IS_SP && (push || pop)))
      |=> regs[gi][DW-1:DW/2] == $past(regs[gi][DW-1:DW/2]));

    // R5: an illegal byte view leaves the register untouched
    a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_int_n)
      (wr_err && wr_idx == IW'(gi) && !(IS_SP && (push || pop)))
      |=> $stable(regs[gi]));
  end

  // R8: push moves the stack pointer down one slot
  a_r8_push_dec: assert property (@(posedge clk) disable iff (!rst_int_n)
    push |=> regs[SP_IDX] == $past(regs[SP_IDX]) - STEP_V);

  // R9: pop alone moves the stack pointer up one slot
  a_r9_pop_inc: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pop && !push) |=> regs[SP_IDX] == $past(regs[SP_IDX]) + STEP_V);

  // R5: error only for byte views above the byte-capable range
  a_r5_err_scope: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_err |-> (wr_en && wr_view[1] && wr_idx >= BYTE_LIM));
endmodule

// File: tb/aliased_regfile_test.sv
module aliased_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [1:0]  wr_view;
  logic [31:0] wr_data;
  logic        wr_err;
  logic [2:0]  ra_idx, rb_idx;
  logic [1:0]  ra_view, rb_view;
  logic        ra_sext, ra_narrow, rb_sext, rb_narrow;
  logic [31:0] ra_data, rb_data;
  logic        push, pop;
  logic [31:0] stk_addr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] mdl [8];

  always #4 clk = ~clk;

  aliased_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view),
    .wr_data(wr_data), .wr_err(wr_err), .ra_idx(ra_idx), .ra_view(ra_view),
    .ra_sext(ra_sext), .ra_narrow(ra_narrow), .ra_data(ra_data), .rb_idx(rb_idx),
    .rb_view(rb_view), .rb_sext(rb_sext), .rb_narrow(rb_narrow), .rb_data(rb_data),
    .push(push), .pop(pop), .stk_addr(stk_addr)
  );

  function automatic logic [31:0] f_read(logic [31:0] r, logic [2:0] idx,
                                         logic [1:0] v, logic s, logic n);
    logic [7:0]  b;
    logic [15:0] h;
    if (v == 2'd0) return r;
    if (v == 2'd1) begin
      h = r[15:0];
      return n ? {16'h0, h} : {{16{s & h[15]}}, h};
    end
    if (idx >= 3'd4) return 32'h0;
    b = (v == 2'd2) ? r[7:0] : r[15:8];
    return n ? {16'h0, {8{s & b[7]}}, b} : {{24{s & b[7]}}, b};
  endfunction

  function automatic logic [31:0] f_merge(logic [31:0] o, logic [1:0] v, logic [31:0] d);
    case (v)
      2'd0: return d;
      2'd1: return {o[31:16], d[15:0]};
      2'd2: return {o[31:8], d[7:0]};
      default: return {o[31:16], d[7:0], o[7:0]};
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_idx = 0; wr_view = 0; wr_data = 0;
    ra_idx = 0; ra_view = 0; ra_sext = 0; ra_narrow = 0;
    rb_idx = 0; rb_view = 0; rb_sext = 0; rb_narrow = 0;
    push = 0; pop = 0;
  endtask

  // inputs set just after a falling edge; check, clock, update model
  task automatic cyc(string tag);
    logic        e_err;
    logic [31:0] sp;
    #1;
    e_err = wr_en && wr_view[1] && (wr_idx >= 3'd4);
    sp = mdl[4];
    chk(tag, ra_data, f_read(mdl[ra_idx], ra_idx, ra_view, ra_sext, ra_narrow));
    chk(tag, rb_data, f_read(mdl[rb_idx], rb_idx, rb_view, rb_sext, rb_narrow));
    chk({tag, " wr_err"}, {31'h0, wr_err}, {31'h0, e_err});
    if (push)     chk({tag, " stk_addr"}, stk_addr, sp - 32'd4);
    else if (pop) chk({tag, " stk_addr"}, stk_addr, sp);
    @(posedge clk);
    if (wr_en && !e_err && !(wr_idx == 3'd4 && (push || pop)))
      mdl[wr_idx] = f_merge(mdl[wr_idx], wr_view, wr_data);
    if (push)     mdl[4] = sp - 32'd4;
    else if (pop) mdl[4] = sp + 32'd4;
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] i, logic [1:0] v, logic [31:0] d, string tag);
    idle(); wr_en = 1; wr_idx = i; wr_view = v; wr_data = d;
    ra_idx = i; rb_idx = i;
    cyc(tag);
  endtask

  task automatic rd(logic [2:0] i, logic [1:0] v, logic s, logic n, string tag);
    idle(); ra_idx = i; ra_view = v; ra_sext = s; ra_narrow = n;
    rb_idx = i; rb_view = v; rb_sext = ~s; rb_narrow = n;
    cyc(tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 8; i++) rd(3'(i), 2'd0, 1'b0, 1'b0, "R1");

    // full write, read of old value in the same cycle
    wr(3'd2, 2'd0, 32'h89AB_CDEF, "R11");
    chk("R2 model", mdl[2], 32'h89AB_CDEF);
    rd(3'd2, 2'd0, 1'b0, 1'b0, "R2");
    wr(3'd2, 2'd1, 32'hFFFF_1234, "R3");
    rd(3'd2, 2'd0, 1'b0, 1'b0, "R3");
    chk("R3 value", ra_data, 32'h89AB_1234);
    wr(3'd2, 2'd2, 32'hFFFF_FF56, "R4");
    wr(3'd2, 2'd3, 32'h0000_009A, "R4");
    rd(3'd2, 2'd0, 1'b0, 1'b0, "R4");
    chk("R4 value", ra_data, 32'h89AB_9A56);

    wr(3'd6, 2'd0, 32'h1122_3344, "R2");
    wr(3'd6, 2'd3, 32'h0000_00EE, "R5");
    wr(3'd5, 2'd2, 32'h0000_00EE, "R5");
    rd(3'd6, 2'd0, 1'b0, 1'b0, "R5");
    chk("R5 value", ra_data, 32'h1122_3344);
    rd(3'd6, 2'd3, 1'b1, 1'b0, "R6");
    rd(3'd6, 2'd2, 1'b0, 1'b1, "R6");

    rd(3'd2, 2'd3, 1'b1, 1'b0, "R7");
    chk("R7 sext byte", ra_data, 32'hFFFF_FF9A);
    chk("R7 zext byte", rb_data, 32'h0000_009A);
    rd(3'd2, 2'd3, 1'b1, 1'b1, "R7");
    chk("R7 byte to 16", ra_data, 32'h0000_FF9A);
    rd(3'd2, 2'd1, 1'b1, 1'b0, "R7");
    chk("R7 word", ra_data, 32'hFFFF_9A56);
    chk("R7 word zext", rb_data, 32'h0000_9A56);

    wr(3'd4, 2'd0, 32'h0000_1000, "R8");
    idle(); push = 1; ra_idx = 4; cyc("R8");
    rd(3'd4, 2'd0, 1'b0, 1'b0, "R8");
    chk("R8 sp", ra_data, 32'h0000_0FFC);
    idle(); pop = 1; ra_idx = 4; cyc("R9");
    rd(3'd4, 2'd0, 1'b0, 1'b0, "R9");
    chk("R9 sp", ra_data, 32'h0000_1000);
    idle(); push = 1; pop = 1; wr_en = 1; wr_idx = 4; wr_data = 32'hDEAD_BEEF; cyc("R10");
    rd(3'd4, 2'd0, 1'b0, 1'b0, "R10");
    chk("R10 sp", ra_data, 32'h0000_0FFC);

    idle(); ra_idx = 2; ra_view = 2'd2; ra_sext = 1; rb_idx = 6; rb_view = 2'd1; cyc("R12");

    for (int k = 0; k < 3000; k++) begin
      wr_en = $urandom_range(0, 1); wr_idx = 3'($urandom); wr_view = 2'($urandom);
      wr_data = $urandom;
      ra_idx = 3'($urandom); ra_view = 2'($urandom);
      ra_sext = 1'($urandom); ra_narrow = 1'($urandom);
      rb_idx = 3'($urandom); rb_view = 2'($urandom);
      rb_sext = 1'($urandom); rb_narrow = 1'($urandom);
      push = ($urandom_range(0, 7) == 0); pop = ($urandom_range(0, 7) == 0);
      cyc("R12 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule